// File: doc/BRIEF.md
# Descriptor Ring Queue Manager

This block is a bus-master queue engine for the transmit side of a packet interface. It walks a ring of two-word descriptors held in shared memory. For each descriptor it reads the frame buffer word by word, and it presents the words on a valid/ready streaming port. When the frame has gone out, it writes one completion word into a matching status ring. Software sets a base address, a current address and a byte length for each ring through a small register port. It then hands entries to the engine by writing a count to an enqueue register. Ownership is tracked by this count alone. There are no ownership bits inside the descriptors.

The status ring steps in lockstep with the descriptor ring, so a single credit count covers both rings. The engine waits while the credit count is zero. A soft-reset bit clears the run state: the credit, the two current pointers, the enable bit and the active flag. Base and length settings survive a soft reset. The memory side is a word-aligned request/acknowledge port with one request in flight.

Top module: `ring_queue_mgr`

## Requirements
- R1: After reset, the control, status and enqueue registers read 0, and neither a memory request nor a stream beat is issued.
- R2: Writing 1 to control bit 0 (enable) makes status bit 0 (active) read 1 one cycle after the write takes effect. Clearing enable clears active in the same way.
- R3: A write of N to the enqueue register adds N to the credit count. The sum saturates at 2^CREDIT_W-1 and never wraps. Reading the enqueue register returns the current credit. Each completed frame consumes one credit.
- R4: While the credit is zero, or while active is low, the engine issues no memory request. It starts on the first cycle after an enqueue write that raises the credit.
- R5: A frame starts with two reads. Word 0 is read at the descriptor current address and gives the buffer address. Word 1 is read at that address plus 4 and holds the frame length in bytes in bits [15:0] and the end-of-frame flag in bit 31.
- R6: A good frame of L bytes sends ceil(L/4) words from consecutive buffer addresses, in order. tx_last marks only the final word. Data and tx_last hold steady while tx_ready is low.
- R7: After the last beat is accepted, one status word is written at the status current address. It holds the processed flag in bit 31, the no-error flag in bit 30 and the frame length in bits [15:0], all in that one write.
- R8: A descriptor whose length is 0, whose length exceeds MAX_BYTES, or whose end-of-frame flag is clear sends no data. It still gets a status word with processed=1 and no-error=0.
- R9: After each status write, the descriptor pointer advances by 8 and the status pointer by 4. A pointer that reaches base+length wraps to base.
- R10: Writing 1 to control bit 1 starts a soft reset. The bit reads 1 until the cycle after the write and then clears by itself. The soft reset sets credit, enable and active to 0 and reloads both current pointers from their bases.
- R11: A memory request keeps its address, write flag and data unchanged until it is acknowledged.
- R12: The register word offsets are: 0 control, 1 status, 2 descriptor base, 3 descriptor current, 4 descriptor length, 5 status base, 6 status current, 7 status length, 8 enqueue. A write to a current register loads that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream word valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 32 | Stream word |
| tx_last | output | 1 | Final word of the frame |

## Verification
The assertions assume the following about the inputs. The memory raises mem_ack for one cycle, and only for a request that is outstanding. Software leaves the bases and lengths unchanged while frames are in flight. It keeps each current pointer inside its ring and sets each ring length to a whole number of entries. The bench meets these assumptions: its memory model acknowledges one cycle after it sees a request, it sets up the rings once before enabling the engine, and it issues a soft reset only after it has disabled the engine and the engine is idle.

// File: rtl/dqm_pkg.sv
`timescale 1ns/1ps
// Package: shared state type, register offsets and ring entry sizes.
package dqm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_DESC0, ST_DESC1, ST_FETCH, ST_SEND, ST_STATUS
    } eng_state_t;

    localparam logic [3:0] RA_CTRL  = 4'h0;
    localparam logic [3:0] RA_STAT  = 4'h1;
    localparam logic [3:0] RA_DBASE = 4'h2;
    localparam logic [3:0] RA_DCUR  = 4'h3;
    localparam logic [3:0] RA_DLEN  = 4'h4;
    localparam logic [3:0] RA_SBASE = 4'h5;
    localparam logic [3:0] RA_SCUR  = 4'h6;
    localparam logic [3:0] RA_SLEN  = 4'h7;
    localparam logic [3:0] RA_ENQ   = 4'h8;

    localparam int DESC_BYTES = 8;
    localparam int STS_BYTES  = 4;
endpackage

// File: rtl/dqm_csr.sv
`timescale 1ns/1ps
// Module: register file, credit counter and soft-reset sequencing.
// Assumes a single write port; reads are combinational on cfg_addr.
// Ring index 0 is the descriptor ring, index 1 the status ring.
module dqm_csr
    import dqm_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CREDIT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [3:0]             cfg_addr,
    input  logic [31:0]            cfg_wdata,
    output logic [31:0]            cfg_rdata,
    input  logic                   consume,
    input  logic [1:0][ADDR_W-1:0] ring_cur,
    output logic [1:0][ADDR_W-1:0] ring_base,
    output logic [1:0][ADDR_W-1:0] ring_len,
    output logic [1:0]             cur_ld,
    output logic [1:0][ADDR_W-1:0] cur_ld_val,
    output logic                   active,
    output logic                   credit_nz,
    output logic                   srst
);
    localparam logic [32:0] CMAX = 33'((64'd1 << CREDIT_W) - 64'd1);

    logic                en;
    logic                srst_pend;
    logic [CREDIT_W-1:0] credit;
    logic [CREDIT_W-1:0] credit_nx;
    logic [32:0]         add_w;
    logic [32:0]         sat_w;
    logic                enq_wr;

    assign enq_wr    = cfg_we && (cfg_addr == RA_ENQ);
    assign srst      = srst_pend;
    assign credit_nz = (credit != '0);

    // Credit update: saturating add of the enqueue value, minus one per frame.
    always_comb begin
        add_w     = 33'(credit) + (enq_wr ? {1'b0, cfg_wdata} : 33'd0);
        sat_w     = (add_w > CMAX) ? CMAX : add_w;
        credit_nx = sat_w[CREDIT_W-1:0] - (consume ? CREDIT_W'(1) : CREDIT_W'(0));
    end

    // Pointer load strobes: software write, or reload from base on soft reset.
    always_comb begin
        cur_ld[0]     = srst_pend || (cfg_we && (cfg_addr == RA_DCUR));
        cur_ld[1]     = srst_pend || (cfg_we && (cfg_addr == RA_SCUR));
        cur_ld_val[0] = srst_pend ? ring_base[0] : cfg_wdata[ADDR_W-1:0];
        cur_ld_val[1] = srst_pend ? ring_base[1] : cfg_wdata[ADDR_W-1:0];
    end

    // Register state, with soft reset taking priority over software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en        <= 1'b0;
            srst_pend <= 1'b0;
            active    <= 1'b0;
            credit    <= '0;
            ring_base <= '0;
            ring_len  <= '0;
        end else if (srst_pend) begin
            en        <= 1'b0;
            srst_pend <= 1'b0;
            active    <= 1'b0;
            credit    <= '0;
        end else begin
            active <= en;
            credit <= credit_nx;
            if (cfg_we) begin
                case (cfg_addr)
                    RA_CTRL: begin
                        en        <= cfg_wdata[0];
                        srst_pend <= cfg_wdata[1];
                    end
                    RA_DBASE: ring_base[0] <= cfg_wdata[ADDR_W-1:0];
                    RA_DLEN:  ring_len[0]  <= cfg_wdata[ADDR_W-1:0];
                    RA_SBASE: ring_base[1] <= cfg_wdata[ADDR_W-1:0];
                    RA_SLEN:  ring_len[1]  <= cfg_wdata[ADDR_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Read mux for the register port.
    always_comb begin
        case (cfg_addr)
            RA_CTRL:  cfg_rdata = {30'd0, srst_pend, en};
            RA_STAT:  cfg_rdata = {31'd0, active};
            RA_DBASE: cfg_rdata = 32'(ring_base[0]);
            RA_DCUR:  cfg_rdata = 32'(ring_cur[0]);
            RA_DLEN:  cfg_rdata = 32'(ring_len[0]);
            RA_SBASE: cfg_rdata = 32'(ring_base[1]);
            RA_SCUR:  cfg_rdata = 32'(ring_cur[1]);
            RA_SLEN:  cfg_rdata = 32'(ring_len[1]);
            RA_ENQ:   cfg_rdata = 32'(credit);
            default:  cfg_rdata = 32'd0;
        endcase
    end

    // R10: the soft-reset request lasts exactly one cycle.
    a_r10_srst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        srst_pend |=> !srst_pend);

    // R3: a full credit count is never lowered except by a consumed frame.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (33'(credit) == CMAX && !consume && !srst_pend) |=> (33'(credit) == CMAX));

    // R2: active follows enable one cycle later.
    a_r2_active_follows: assert property (@(posedge clk) disable iff (!rst_n || srst_pend)
        $rose(en) |=> active);
endmodule

// File: rtl/dqm_ring_ptr.sv
`timescale 1ns/1ps
// Module: current-entry pointer of one ring, advancing by STEP bytes and wrapping.
// Assumes the base and length stay fixed while the ring is in use,
// and that the length is a whole number of entries.
module dqm_ring_ptr #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [ADDR_W-1:0] ring_len,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur
);
    logic [ADDR_W-1:0] ring_end;
    logic [ADDR_W-1:0] step_nx;

    assign ring_end = ring_base + ring_len;
    assign step_nx  = cur + ADDR_W'(STEP);

    // Pointer register: a load wins; otherwise step, wrapping to base at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur <= '0;
        else if (load)    cur <= load_val;
        else if (advance) cur <= (step_nx >= ring_end) ? ring_base : step_nx;
    end

    // R9: a pointer inside its ring stays inside it after an advance.
    a_r9_stay_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && cur >= ring_base && cur < ring_end)
        |=> (!$stable(ring_base) || !$stable(ring_len) || (cur >= ring_base && cur < ring_end)));
endmodule

// File: rtl/dqm_engine.sv
`timescale 1ns/1ps
// Module: frame sequencer. It fetches the two descriptor words, streams the
// buffer one word at a time and writes the single completion word.
// Assumes mem_ack pulses once per outstanding request, with read data valid in that cycle.
module dqm_engine
    import dqm_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              active,
    input  logic              credit_nz,
    input  logic [ADDR_W-1:0] d_cur,
    input  logic [ADDR_W-1:0] s_cur,
    output logic              consume,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_data,
    output logic              tx_last
);
    eng_state_t        state;
    logic [ADDR_W-1:0] buf_ptr;
    logic [LEN_W-1:0]  frm_len;
    logic              frm_ok;
    logic [LEN_W:0]    words_left;
    logic [31:0]       hold_word;

    logic [LEN_W-1:0]  dlen;
    logic              d_good;
    logic [LEN_W:0]    d_words;

    assign dlen    = mem_rdata[LEN_W-1:0];
    assign d_good  = mem_rdata[31] && (dlen != '0) && (32'(dlen) <= 32'(MAX_BYTES));
    assign d_words = ({1'b0, dlen} + (LEN_W+1)'(3)) >> 2;

    // Memory port decode from the sequencer state.
    always_comb begin
        mem_req = (state == ST_DESC0) || (state == ST_DESC1) ||
                  (state == ST_FETCH) || (state == ST_STATUS);
        mem_we  = (state == ST_STATUS);
        case (state)
            ST_DESC0:  mem_addr = d_cur;
            ST_DESC1:  mem_addr = d_cur + ADDR_W'(4);
            ST_FETCH:  mem_addr = buf_ptr;
            ST_STATUS: mem_addr = s_cur;
            default:   mem_addr = '0;
        endcase
        mem_wdata = {1'b1, frm_ok, (30-LEN_W)'(0), frm_len};
    end

    assign consume  = (state == ST_STATUS) && mem_ack;
    assign tx_valid = (state == ST_SEND);
    assign tx_data  = hold_word;
    assign tx_last  = tx_valid && (words_left == (LEN_W+1)'(1));

    // Sequencer: idle -> descriptor words -> (fetch/send)* -> status.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            state      <= ST_IDLE;
            buf_ptr    <= '0;
            frm_len    <= '0;
            frm_ok     <= 1'b0;
            words_left <= '0;
            hold_word  <= '0;
        end else begin
            case (state)
                ST_IDLE:
                    if (active && credit_nz) state <= ST_DESC0;
                ST_DESC0:
                    if (mem_ack) begin
                        buf_ptr <= mem_rdata[ADDR_W-1:0];
                        state   <= ST_DESC1;
                    end
                ST_DESC1:
                    if (mem_ack) begin
                        frm_len    <= dlen;
                        frm_ok     <= d_good;
                        words_left <= d_words;
                        state      <= d_good ? ST_FETCH : ST_STATUS;
                    end
                ST_FETCH:
                    if (mem_ack) begin
                        hold_word <= mem_rdata;
                        state     <= ST_SEND;
                    end
                ST_SEND:
                    if (tx_ready) begin
                        if (words_left == (LEN_W+1)'(1)) begin
                            state <= ST_STATUS;
                        end else begin
                            words_left <= words_left - (LEN_W+1)'(1);
                            buf_ptr    <= buf_ptr + ADDR_W'(4);
                            state      <= ST_FETCH;
                        end
                    end
                ST_STATUS:
                    if (mem_ack) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: no request follows an idle cycle without credit.
    a_r4_no_fetch_without_credit: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (state == ST_IDLE && !credit_nz) |=> !mem_req);

    // R11: an unacknowledged request holds its address and direction.
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R6: a stalled beat keeps its data and last marker.
    a_r6_beat_hold: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R7: the completion write follows the final accepted beat directly.
    a_r7_status_after_last: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (tx_valid && tx_ready && tx_last) |=> (mem_req && mem_we && mem_wdata[31] && mem_wdata[30]));

    // R8: a rejected descriptor goes straight to an error completion.
    a_r8_bad_desc_status: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (state == ST_DESC1 && mem_ack && !d_good) |=> (mem_we && !mem_wdata[30] && !tx_valid));
endmodule

// File: rtl/ring_queue_mgr.sv
`timescale 1ns/1ps
// Module: top of the descriptor ring queue manager. It joins the register
// file, one pointer per ring (built by generate) and the frame sequencer.
// Assumes a single outstanding memory request and word-aligned addresses.
module ring_queue_mgr
    import dqm_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CREDIT_W  = 8,
    parameter int LEN_W     = 16,
    parameter int MAX_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_data,
    output logic              tx_last
);
    localparam int NUM_RINGS = 2;

    logic [NUM_RINGS-1:0][ADDR_W-1:0] ring_base;
    logic [NUM_RINGS-1:0][ADDR_W-1:0] ring_len;
    logic [NUM_RINGS-1:0][ADDR_W-1:0] ring_cur;
    logic [NUM_RINGS-1:0]             cur_ld;
    logic [NUM_RINGS-1:0][ADDR_W-1:0] cur_ld_val;
    logic active, credit_nz, srst, consume;

    dqm_csr #(.ADDR_W(ADDR_W), .CREDIT_W(CREDIT_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .consume(consume),
        .ring_cur(ring_cur), .ring_base(ring_base), .ring_len(ring_len),
        .cur_ld(cur_ld), .cur_ld_val(cur_ld_val), .active(active),
        .credit_nz(credit_nz), .srst(srst)
    );

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        localparam int STEP = (g == 0) ? DESC_BYTES : STS_BYTES;
        dqm_ring_ptr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_ptr (
            .clk(clk), .rst_n(rst_n), .ring_base(ring_base[g]),
            .ring_len(ring_len[g]), .load(cur_ld[g]), .load_val(cur_ld_val[g]),
            .advance(consume), .cur(ring_cur[g])
        );
    end

    dqm_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES)) u_eng (
        .clk(clk), .rst_n(rst_n), .srst(srst), .active(active),
        .credit_nz(credit_nz), .d_cur(ring_cur[0]), .s_cur(ring_cur[1]),
        .consume(consume), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last)
    );

    // R1: nothing moves on either port straight out of reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !tx_valid));
endmodule

// File: tb/sim_ring_queue_mgr.sv
`timescale 1ns/1ps
// Bench: memory model, stream sink, a table of frames walked by one loop,
// then directed checks of saturation and soft reset.
module sim_ring_queue_mgr;
    localparam int ADDR_W = 32;
    localparam logic [31:0] DBASE = 32'h100;
    localparam logic [31:0] SBASE = 32'h200;
    localparam int NSLOT = 4;
    // Frame table: bit31 end-of-frame, bit30 expected no-error, [15:0] length.
    localparam logic [31:0] VEC [0:6] = '{
        32'hC000_000C, 32'hC000_0005, 32'hC000_0001, 32'h8000_0000,
        32'h8000_012C, 32'h0000_0010, 32'hC000_0100
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_we, mem_ack, tx_valid, tx_ready, tx_last;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata, tx_data;

    ring_queue_mgr u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
    );

    // Memory model: acknowledges one cycle after a request; bench backdoor writes.
    logic [31:0] mem [0:1023];
    logic        bw_en = 1'b0;
    logic [31:0] bw_addr = 32'h0, bw_data = 32'h0;
    logic        ack_q;
    logic [31:0] rd_q;
    assign mem_ack   = ack_q;
    assign mem_rdata = rd_q;
    always @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            rd_q  <= 32'h0;
        end else if (mem_req && !ack_q) begin
            ack_q <= 1'b1;
            rd_q  <= mem[mem_addr[11:2]];
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        end else begin
            ack_q <= 1'b0;
        end
        if (bw_en) mem[bw_addr[11:2]] <= bw_data;
    end

    // Monitors: accepted request addresses and accepted stream beats.
    logic [31:0] log_addr [0:511];
    logic [31:0] cap [0:511];
    logic        cap_last [0:511];
    int log_n, cap_n;
    always @(posedge clk) begin
        if (!rst_n) begin
            log_n <= 0;
            cap_n <= 0;
        end else begin
            if (mem_req && mem_ack) begin
                log_addr[log_n % 512] <= mem_addr;
                log_n <= log_n + 1;
            end
            if (tx_valid && tx_ready) begin
                cap[cap_n % 512]      <= tx_data;
                cap_last[cap_n % 512] <= tx_last;
                cap_n <= cap_n + 1;
            end
        end
    end

    // Sink backpressure pattern, and a request stability monitor (R11).
    logic bp = 1'b0;
    int   cyc = 0;
    logic l_req = 1'b0, l_ack = 1'b0;
    logic [31:0] l_addr = 32'h0;
    int   viol = 0;
    always @(negedge clk) begin
        cyc      <= cyc + 1;
        tx_ready <= bp ? ((cyc % 3) != 0) : 1'b1;
        if (rst_n && l_req && !l_ack && (!mem_req || mem_addr != l_addr)) viol <= viol + 1;
        l_req  <= mem_req;
        l_ack  <= mem_ack;
        l_addr <= mem_addr;
    end

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [3:0] a, output logic [31:0] d);
        cfg_addr = a;
        #0.2;
        d = cfg_rdata;
    endtask

    task automatic mem_wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bw_en = 1'b1; bw_addr = a; bw_data = d;
        @(negedge clk);
        bw_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_rd(4'h0, rv); chk("R1 control after reset", rv, 32'h0);
        cfg_rd(4'h1, rv); chk("R1 status after reset", rv, 32'h0);
        cfg_rd(4'h8, rv); chk("R1 credit after reset", rv, 32'h0);
        chk("R1 ports idle", {30'd0, mem_req, tx_valid}, 32'h0);

        cfg_wr(4'h2, DBASE); cfg_wr(4'h3, DBASE); cfg_wr(4'h4, 32'(NSLOT * 8));
        cfg_wr(4'h5, SBASE); cfg_wr(4'h6, SBASE); cfg_wr(4'h7, 32'(NSLOT * 4));
        cfg_rd(4'h4, rv); chk("R12 descriptor length readback", rv, 32'd32);
        cfg_rd(4'h6, rv); chk("R12 status current readback", rv, SBASE);
        cfg_wr(4'h0, 32'h1);
        @(negedge clk);
        cfg_rd(4'h1, rv); chk("R2 active after enable", rv, 32'h1);

        for (int i = 0; i < 7; i++) begin
            logic [15:0] len;
            logic        ok;
            int          nb, ls, cs;
            logic [31:0] d_a, s_a, b_a;
            len = VEC[i][15:0];
            ok  = VEC[i][30];
            nb  = ok ? ((int'(len) + 3) / 4) : 0;
            d_a = DBASE + 32'(8 * (i % NSLOT));
            s_a = SBASE + 32'(4 * (i % NSLOT));
            b_a = 32'h400 + 32'(i * 256);
            for (int k = 0; k < nb; k++) mem_wr(b_a + 32'(4 * k), 32'hA000_0000 | 32'(i << 8) | 32'(k));
            mem_wr(d_a, b_a);
            mem_wr(d_a + 4, {VEC[i][31], 15'd0, len});
            mem_wr(s_a, 32'h0);
            bp = i[0];
            ls = log_n;
            cs = cap_n;
            if (i == 0) begin
                repeat (16) @(negedge clk);
                chk("R4 no fetch with zero credit", 32'(log_n - ls), 32'h0);
            end
            cfg_wr(4'h8, 32'h1);
            for (int t = 0; t < 3000 && !mem[s_a[11:2]][31]; t++) @(negedge clk);
            repeat (3) @(negedge clk);
            chk($sformatf("R7 R8 status word frame %0d", i), mem[s_a[11:2]],
                {1'b1, ok, 14'd0, len});
            chk($sformatf("R6 R8 beat count frame %0d", i), 32'(cap_n - cs), 32'(nb));
            for (int k = 0; k < nb; k++)
                chk($sformatf("R6 data frame %0d word %0d", i, k), cap[(cs + k) % 512],
                    32'hA000_0000 | 32'(i << 8) | 32'(k));
            if (nb > 0) chk("R6 last flag on final word", 32'(cap_last[(cs + nb - 1) % 512]), 32'h1);
            if (nb > 1) chk("R6 no last flag before final word", 32'(cap_last[(cs + nb - 2) % 512]), 32'h0);
            chk("R5 descriptor word 0 address", log_addr[ls % 512], d_a);
            chk("R5 descriptor word 1 address", log_addr[(ls + 1) % 512], d_a + 4);
            if (nb > 0) chk("R6 first buffer read address", log_addr[(ls + 2) % 512], b_a);
            chk("R7 status write address", log_addr[(ls + 2 + nb) % 512], s_a);
            cfg_rd(4'h3, rv); chk("R9 descriptor pointer step/wrap", rv, DBASE + 32'(8 * ((i + 1) % NSLOT)));
            cfg_rd(4'h6, rv); chk("R9 status pointer step/wrap", rv, SBASE + 32'(4 * ((i + 1) % NSLOT)));
            cfg_rd(4'h8, rv); chk("R3 credit consumed", rv, 32'h0);
        end
        bp = 1'b0;

        cfg_wr(4'h0, 32'h0);
        @(negedge clk);
        cfg_rd(4'h1, rv); chk("R2 active cleared by disable", rv, 32'h0);
        cfg_wr(4'h8, 32'd200);
        cfg_rd(4'h8, rv); chk("R3 credit add", rv, 32'd200);
        cfg_wr(4'h8, 32'd100);
        cfg_rd(4'h8, rv); chk("R3 credit saturates", rv, 32'd255);
        cfg_wr(4'h0, 32'h1);
        cfg_wr(4'h0, 32'h0);
        cfg_rd(4'h3, rv); chk("R9 pointer before soft reset", rv, DBASE + 32'h18);

        repeat (8) @(negedge clk);
        cfg_wr(4'h0, 32'h2);
        cfg_rd(4'h0, rv); chk("R10 soft reset bit reads 1", rv, 32'h2);
        @(negedge clk);
        cfg_rd(4'h0, rv); chk("R10 soft reset bit self-clears", rv, 32'h0);
        cfg_rd(4'h8, rv); chk("R10 credit cleared", rv, 32'h0);
        cfg_rd(4'h1, rv); chk("R10 active cleared", rv, 32'h0);
        cfg_rd(4'h3, rv); chk("R10 descriptor pointer reloaded", rv, DBASE);
        cfg_rd(4'h6, rv); chk("R10 status pointer reloaded", rv, SBASE);
        cfg_rd(4'h2, rv); chk("R10 base kept", rv, DBASE);

        chk("R11 requests held until acknowledged", 32'(viol), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule